// File: doc/BRIEF.md
# GPIO Bank Pin Configuration Registers

This block holds the configuration of one 32-pin general-purpose I/O bank behind a 32-bit register bus. Each pin has a 4-bit function code, a 2-bit drive-strength field, a 2-bit pull-select field and one data bit. The function code sets the pin's direction. Code 0 makes the pin an input. Code 1 makes it a driven output. Code 6 hands the pin to the external interrupt logic. Any other code gives the pad to a peripheral, and the block then drops its output enable.

The pin side carries the per-pin output value, output enable, function code, interrupt routing flag, drive and pull fields. Pin input levels pass through a two-stage synchronizer. Reading the data word gives the driven value for output pins and the synchronized input level for every other pin.

The bus is a simple select/write strobe with a word address. Writes take effect on the rising clock edge. Read data is combinational from the address while select is high.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every function, data, drive and pull field is 0, so all pins are inputs with output enable low, output value low and interrupt routing low.
- R2: Pin n's function code is held in word n/8 (word addresses 0 to 3) at bits (n%8)*4+3 down to (n%8)*4. It reads back as written and appears on pin_fsel bits n*4+3:n*4.
- R3: Pin n's drive field is held in word 5 + n/16 at bits (n%16)*2+1:(n%16)*2. It reads back as written and appears on pin_drv bits n*2+1:n*2.
- R4: Pin n's pull field is held in word 7 + n/16 at bits (n%16)*2+1:(n%16)*2. It reads back as written and appears on pin_pul bits n*2+1:n*2.
- R5: pin_oe[n] is high exactly when pin n's function code is 1. Codes 0, 6 and every other code leave it low.
- R6: pin_eint[n] is high exactly when pin n's function code is 6, and it is never high together with pin_oe[n].
- R7: Reading the data word (word address 4) returns, in bit n, the stored data bit when pin n's code is 1. For any other code it returns pin n's synchronized input level.
- R8: A change on pin_in shows in the data-word read value after two rising clock edges, and not after only one.
- R9: Word addresses 9 to 15 are unmapped. They read as zero, and writes to them change no mapped field.
- R10: pin_out carries the stored data bit of every pin, whatever the pin's function code.
- R11: The registers change only on a clock edge where bus_sel and bus_wr are both high. A write strobe without select changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (read when low) |
| bus_addr | input | 4 | Word address (byte offset bits 5:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| pin_in | input | 32 | Pad input levels |
| pin_out | output | 32 | Per-pin output value |
| pin_oe | output | 32 | Per-pin output enable |
| pin_eint | output | 32 | Per-pin routing to interrupt logic |
| pin_fsel | output | 128 | Per-pin 4-bit function code |
| pin_drv | output | 64 | Per-pin 2-bit drive strength |
| pin_pul | output | 64 | Per-pin 2-bit pull select |

## Verification
The function words are loaded with a ramp of every code 0 to 15 and with repeated single codes. This separates a field that lands in the wrong nibble from one that is decoded wrongly into direction or interrupt routing. The data word is read under all-input, all-output, all-peripheral and mixed code patterns, with input levels that differ from the stored bits, so every readback bit shows which source it came from. Drive and pull words use asymmetric patterns, so a swapped word or a field off by one slot shows on the pin outputs. A single input step is sampled one and two edges later to pin down the synchronizer depth. Unmapped and unselected writes of all ones are followed by a full readback.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PIN_CNT = 32;
  localparam int BUS_W   = 32;
  localparam int ADDR_W  = 6;
  localparam int FSEL_W  = 4;
  localparam int DRV_W   = 2;
  localparam int PUL_W   = 2;

  localparam int WIDX_W        = ADDR_W - 2;
  localparam int FSEL_PER_WORD = BUS_W / FSEL_W;
  localparam int FSEL_WORDS    = PIN_CNT / FSEL_PER_WORD;
  localparam int DRV_PER_WORD  = BUS_W / DRV_W;
  localparam int DRV_WORDS     = PIN_CNT / DRV_PER_WORD;
  localparam int PUL_PER_WORD  = BUS_W / PUL_W;
  localparam int PUL_WORDS     = PIN_CNT / PUL_PER_WORD;

  // word map: function words, data word, drive words, pull words
  localparam int FSEL_BASE  = 0;
  localparam int DATA_IDX   = FSEL_BASE + FSEL_WORDS;
  localparam int DRV_BASE   = DATA_IDX + 1;
  localparam int PUL_BASE   = DRV_BASE + DRV_WORDS;
  localparam int WORDS_USED = PUL_BASE + PUL_WORDS;

  localparam logic [FSEL_W-1:0] FN_IN   = 4'd0;
  localparam logic [FSEL_W-1:0] FN_OUT  = 4'd1;
  localparam logic [FSEL_W-1:0] FN_EINT = 4'd6;

  function automatic int fsel_word(input int pin);
    return pin / FSEL_PER_WORD;
  endfunction
  function automatic int fsel_lsb(input int pin);
    return (pin % FSEL_PER_WORD) * FSEL_W;
  endfunction
  function automatic int drv_word(input int pin);
    return pin / DRV_PER_WORD;
  endfunction
  function automatic int drv_lsb(input int pin);
    return (pin % DRV_PER_WORD) * DRV_W;
  endfunction
  function automatic int pul_word(input int pin);
    return pin / PUL_PER_WORD;
  endfunction
  function automatic int pul_lsb(input int pin);
    return (pin % PUL_PER_WORD) * PUL_W;
  endfunction
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs import gpio_bank_pkg::*; (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [WIDX_W-1:0]                   widx,
  input  logic [BUS_W-1:0]                    wdata,
  output logic [FSEL_WORDS-1:0][BUS_W-1:0]    fsel_q,
  output logic [PIN_CNT-1:0]                  data_q,
  output logic [DRV_WORDS-1:0][BUS_W-1:0]     drv_q,
  output logic [PUL_WORDS-1:0][BUS_W-1:0]     pul_q,
  output logic                                map_hit
);
  assign map_hit = (widx < WIDX_W'(WORDS_USED));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsel_q <= '0;
      data_q <= '0;
      drv_q  <= '0;
      pul_q  <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < FSEL_WORDS; k++)
        if (widx == WIDX_W'(FSEL_BASE + k)) fsel_q[k] <= wdata;
      if (widx == WIDX_W'(DATA_IDX)) data_q <= wdata[PIN_CNT-1:0];
      for (int k = 0; k < DRV_WORDS; k++)
        if (widx == WIDX_W'(DRV_BASE + k)) drv_q[k] <= wdata;
      for (int k = 0; k < PUL_WORDS; k++)
        if (widx == WIDX_W'(PUL_BASE + k)) pul_q[k] <= wdata;
    end
  end

  // R11
  no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(fsel_q) && $stable(data_q) && $stable(drv_q) && $stable(pul_q)));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !map_hit) |=> ($stable(fsel_q) && $stable(data_q) && $stable(drv_q) && $stable(pul_q)));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end

  // R8
  first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stage1 == $past(async_in)));

  // R8
  second_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (sync_out == $past(stage1)));
endmodule

// File: rtl/gpio_pin_map.sv
module gpio_pin_map import gpio_bank_pkg::*; (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [FSEL_WORDS-1:0][BUS_W-1:0] fsel_q,
  input  logic [PIN_CNT-1:0]               data_q,
  input  logic [DRV_WORDS-1:0][BUS_W-1:0]  drv_q,
  input  logic [PUL_WORDS-1:0][BUS_W-1:0]  pul_q,
  input  logic [PIN_CNT-1:0]               in_sync,
  output logic [PIN_CNT*FSEL_W-1:0]        pin_fsel,
  output logic [PIN_CNT-1:0]               pin_oe,
  output logic [PIN_CNT-1:0]               pin_eint,
  output logic [PIN_CNT*DRV_W-1:0]         pin_drv,
  output logic [PIN_CNT*PUL_W-1:0]         pin_pul,
  output logic [PIN_CNT-1:0]               rd_level
);
  for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
    localparam int FW = fsel_word(p);
    localparam int FL = fsel_lsb(p);
    localparam int DW = drv_word(p);
    localparam int DL = drv_lsb(p);
    localparam int PW = pul_word(p);
    localparam int PL = pul_lsb(p);

    logic [FSEL_W-1:0] code;
    assign code = fsel_q[FW][FL +: FSEL_W];

    assign pin_fsel[p*FSEL_W +: FSEL_W] = code;
    assign pin_oe[p]   = (code == FN_OUT);
    assign pin_eint[p] = (code == FN_EINT);
    assign pin_drv[p*DRV_W +: DRV_W] = drv_q[DW][DL +: DRV_W];
    assign pin_pul[p*PUL_W +: PUL_W] = pul_q[PW][PL +: PUL_W];
    assign rd_level[p] = pin_oe[p] ? data_q[p] : in_sync[p];
  end

  // R6
  oe_eint_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & pin_eint) == '0);

  // R7
  out_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_level ^ data_q) & pin_oe) == '0);

  // R7
  in_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_level ^ in_sync) & ~pin_oe) == '0);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs import gpio_bank_pkg::*; (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_wr,
  input  logic [ADDR_W-1:2]         bus_addr,
  input  logic [BUS_W-1:0]          bus_wdata,
  output logic [BUS_W-1:0]          bus_rdata,
  input  logic [PIN_CNT-1:0]        pin_in,
  output logic [PIN_CNT-1:0]        pin_out,
  output logic [PIN_CNT-1:0]        pin_oe,
  output logic [PIN_CNT-1:0]        pin_eint,
  output logic [PIN_CNT*FSEL_W-1:0] pin_fsel,
  output logic [PIN_CNT*DRV_W-1:0]  pin_drv,
  output logic [PIN_CNT*PUL_W-1:0]  pin_pul
);
  logic [FSEL_WORDS-1:0][BUS_W-1:0] fsel_q;
  logic [PIN_CNT-1:0]               data_q;
  logic [DRV_WORDS-1:0][BUS_W-1:0]  drv_q;
  logic [PUL_WORDS-1:0][BUS_W-1:0]  pul_q;
  logic                             map_hit;
  logic                             wr_fire;
  logic [PIN_CNT-1:0]               in_sync;
  logic [PIN_CNT-1:0]               rd_level;

  assign wr_fire = bus_sel && bus_wr;

  gpio_cfg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_fire),
    .widx    (bus_addr),
    .wdata   (bus_wdata),
    .fsel_q  (fsel_q),
    .data_q  (data_q),
    .drv_q   (drv_q),
    .pul_q   (pul_q),
    .map_hit (map_hit)
  );

  gpio_in_sync #(.WIDTH(PIN_CNT)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  gpio_pin_map u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .fsel_q   (fsel_q),
    .data_q   (data_q),
    .drv_q    (drv_q),
    .pul_q    (pul_q),
    .in_sync  (in_sync),
    .pin_fsel (pin_fsel),
    .pin_oe   (pin_oe),
    .pin_eint (pin_eint),
    .pin_drv  (pin_drv),
    .pin_pul  (pin_pul),
    .rd_level (rd_level)
  );

  assign pin_out = data_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      for (int k = 0; k < FSEL_WORDS; k++)
        if (bus_addr == WIDX_W'(FSEL_BASE + k)) bus_rdata = fsel_q[k];
      if (bus_addr == WIDX_W'(DATA_IDX)) bus_rdata = rd_level;
      for (int k = 0; k < DRV_WORDS; k++)
        if (bus_addr == WIDX_W'(DRV_BASE + k)) bus_rdata = drv_q[k];
      for (int k = 0; k < PUL_WORDS; k++)
        if (bus_addr == WIDX_W'(PUL_BASE + k)) bus_rdata = pul_q[k];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (fsel_q == '0 && data_q == '0 && drv_q == '0 && pul_q == '0));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !map_hit) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_gpio_bank_regs.sv
`timescale 1ns/1ps
module tb_gpio_bank_regs;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         bus_sel, bus_wr;
  logic [5:2]   bus_addr;
  logic [31:0]  bus_wdata, bus_rdata;
  logic [31:0]  pin_in, pin_out, pin_oe, pin_eint;
  logic [127:0] pin_fsel;
  logic [63:0]  pin_drv, pin_pul;

  always #2 clk = ~clk;

  gpio_bank_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_eint(pin_eint),
    .pin_fsel(pin_fsel), .pin_drv(pin_drv), .pin_pul(pin_pul)
  );

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  bit done   = 0;

  int          m_fsel [32];
  int          m_drv  [32];
  int          m_pul  [32];
  logic [31:0] m_data;
  logic [31:0] m_in;

  typedef struct {
    logic [3:0]  widx;
    logic [31:0] exp;
    string       req;
  } rd_item_t;
  rd_item_t rd_q[$];
  rd_item_t mon_it;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(input int idx);
    logic [31:0] w = '0;
    if (idx < 4) begin
      for (int j = 0; j < 8; j++) w[j*4 +: 4] = 4'(m_fsel[idx*8 + j]);
    end else if (idx == 4) begin
      for (int i = 0; i < 32; i++) w[i] = (m_fsel[i] == 1) ? m_data[i] : m_in[i];
    end else if (idx == 5 || idx == 6) begin
      for (int j = 0; j < 16; j++) w[j*2 +: 2] = 2'(m_drv[(idx-5)*16 + j]);
    end else if (idx == 7 || idx == 8) begin
      for (int j = 0; j < 16; j++) w[j*2 +: 2] = 2'(m_pul[(idx-7)*16 + j]);
    end
    return w;
  endfunction

  task automatic model_store(input int idx, input logic [31:0] d);
    if (idx < 4) begin
      for (int j = 0; j < 8; j++) m_fsel[idx*8 + j] = int'(d[j*4 +: 4]);
    end else if (idx == 4) begin
      m_data = d;
    end else if (idx == 5 || idx == 6) begin
      for (int j = 0; j < 16; j++) m_drv[(idx-5)*16 + j] = int'(d[j*2 +: 2]);
    end else if (idx == 7 || idx == 8) begin
      for (int j = 0; j < 16; j++) m_pul[(idx-7)*16 + j] = int'(d[j*2 +: 2]);
    end
  endtask

  function automatic logic [127:0] model_fsel_flat();
    logic [127:0] v = '0;
    for (int i = 0; i < 32; i++) v[i*4 +: 4] = 4'(m_fsel[i]);
    return v;
  endfunction
  function automatic logic [63:0] model_drv_flat();
    logic [63:0] v = '0;
    for (int i = 0; i < 32; i++) v[i*2 +: 2] = 2'(m_drv[i]);
    return v;
  endfunction
  function automatic logic [63:0] model_pul_flat();
    logic [63:0] v = '0;
    for (int i = 0; i < 32; i++) v[i*2 +: 2] = 2'(m_pul[i]);
    return v;
  endfunction
  function automatic logic [31:0] model_code_mask(input int code);
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) v[i] = (m_fsel[i] == code);
    return v;
  endfunction

  task automatic bus_write(input int idx, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(idx); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    model_store(idx, d);
  endtask

  task automatic bus_read(input int idx, input string req);
    rd_item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'(idx);
    it.widx = 4'(idx); it.exp = model_word(idx); it.req = req;
    rd_q.push_back(it);
    @(posedge clk);
    #2;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops one expected read per access and compares
  always @(posedge clk) begin
    #1;
    if (rd_q.size() > 0) begin
      mon_it = rd_q.pop_front();
      chk($sformatf("%s word%0d", mon_it.req, mon_it.widx), bus_rdata, mon_it.exp);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_in = '0; m_in = '0; m_data = '0;
    for (int i = 0; i < 32; i++) begin m_fsel[i] = 0; m_drv[i] = 0; m_pul[i] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: reset state on the pins and in every mapped word
    chk("R1 oe", pin_oe, 0);
    chk("R1 out", pin_out, 0);
    chk("R1 eint", pin_eint, 0);
    chk("R1 fsel", pin_fsel, 0);
    chk("R1 drv", {pin_drv, pin_pul}, 0);
    for (int w = 0; w < 9; w++) bus_read(w, "R1");

    // R8: input step seen after two edges, not one
    @(negedge clk);
    pin_in = 32'h1234_5678;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 4'd4;
    @(posedge clk); #1;
    chk("R8 one edge", bus_rdata, 32'h0);
    @(posedge clk); #1;
    chk("R8 two edges", bus_rdata, 32'h1234_5678);
    bus_sel = 1'b0;
    m_in = pin_in;

    // R2, R5, R6: function codes, placement and decode
    bus_write(0, 32'h7654_3210);
    bus_write(1, 32'hFEDC_BA98);
    bus_write(2, 32'h1616_1616);
    bus_write(3, 32'h6101_0016);
    for (int w = 0; w < 4; w++) bus_read(w, "R2");
    @(negedge clk);
    chk("R2 pin_fsel", pin_fsel, model_fsel_flat());
    chk("R5 pin_oe", pin_oe, model_code_mask(1));
    chk("R6 pin_eint", pin_eint, model_code_mask(6));

    // R3, R4: drive and pull words
    bus_write(5, 32'hE4E4_1B1B);
    bus_write(6, 32'h0123_4567);
    bus_write(7, 32'h5555_AAAA);
    bus_write(8, 32'h9C9C_3663);
    for (int w = 5; w < 7; w++) bus_read(w, "R3");
    for (int w = 7; w < 9; w++) bus_read(w, "R4");
    @(negedge clk);
    chk("R3 pin_drv", pin_drv, model_drv_flat());
    chk("R4 pin_pul", pin_pul, model_pul_flat());

    // R7, R10: readback source under mixed codes
    pin_in = 32'h3C3C_C3C3; m_in = pin_in;
    bus_write(4, 32'hA5A5_5A5A);
    repeat (3) @(negedge clk);
    chk("R10 pin_out mixed", pin_out, 32'hA5A5_5A5A);
    bus_read(4, "R7 mixed");
    // all outputs
    for (int w = 0; w < 4; w++) bus_write(w, 32'h1111_1111);
    bus_read(4, "R7 all out");
    @(negedge clk);
    chk("R5 all out", pin_oe, 32'hFFFF_FFFF);
    // all peripheral codes
    for (int w = 0; w < 4; w++) bus_write(w, 32'h2222_2222);
    bus_read(4, "R7 peripheral");
    @(negedge clk);
    chk("R5 peripheral", pin_oe, 32'h0);
    chk("R10 pin_out peripheral", pin_out, 32'hA5A5_5A5A);
    // all inputs
    for (int w = 0; w < 4; w++) bus_write(w, 32'h0);
    bus_read(4, "R7 all in");

    // R9: unmapped writes ignored, reads zero
    bus_write(3, 32'h0610_1061);
    bus_write(9, 32'hFFFF_FFFF);
    bus_write(15, 32'hFFFF_FFFF);
    bus_read(9, "R9");
    bus_read(12, "R9");
    bus_read(15, "R9");
    for (int w = 0; w < 9; w++) bus_read(w, "R9 intact");

    // R11: write strobe without select
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr = 1'b0;
    bus_read(3, "R11");
    @(negedge clk);
    chk("R11 pin_fsel", pin_fsel, model_fsel_flat());

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule